// File: doc/BRIEF.md
# Dual-Output Phase-Frequency Detector with Lock Flag

This block compares the timing of two divided clocks inside a frequency synthesizer loop: a divided reference and a divided oscillator. Each arrives as a one-cycle strobe on a fast system clock. A remembered-edge state machine turns the gap between the two strobes into error pulses. One pair of active-low outputs carries them, one output for each side. A single-ended output carries the same error as a drive value plus an output enable, so that a pad wrapper or a charge pump can build the three-state behaviour from it.

When both strobes have been seen, the two internal edge flags stay set together for a fixed minimum window of `MIN_W` clocks and then clear. Because of this, both active-low outputs dip together even when the loop is perfectly aligned. A lock flag drops as soon as one side shows an error on its own. It rises again once a comparison completes with no one-sided error.

The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `pfd_dual_det`

## Requirements
- R1: When the oscillator strobe comes first, `err_vco_n` goes low and `err_ref_n` stays high until the reference strobe arrives. During that one-sided interval `se_oe` is 1 and `se_drive` is 0.
- R2: When the reference strobe comes first, `err_ref_n` goes low and `err_vco_n` stays high until the oscillator strobe arrives. During that interval `se_oe` is 1 and `se_drive` is 1.
- R3: A strobe on an input sets that side's edge flag at the sampling edge, and the output is low from that cycle on. Once both flags are set, both outputs stay low together for exactly `MIN_W` cycles (default 2) and then return high.
- R4: The low pulse of the leading side lasts the number of clocks between the two strobes plus `MIN_W`. Strobes on the same edge give `MIN_W` low cycles on both outputs.
- R5: `se_oe` is 0 whenever both active-low outputs are high, and also whenever both are low.
- R6: If exactly one active-low output is low in a cycle, `locked` is 0 from the next clock edge on.
- R7: `locked` becomes 1 at the edge that ends a comparison's shared window, provided that comparison showed no one-sided cycle. It otherwise holds its value.
- R8: While `rst_n` is low, the edge flags are clear: both active-low outputs are high, `se_oe` is 0 and `locked` is 0. This takes effect at once, even in the middle of a pulse.
- R9: Repeated reference strobes that arrive before any oscillator strobe keep `err_ref_n` low without a break. They do not change the pulse length, which is measured from the first strobe.
- R10: A strobe that arrives on the edge that ends a shared window is not lost. Its flag stays set, and a new comparison starts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_edge_i | input | 1 | One-cycle strobe marking a divided-reference edge |
| vco_edge_i | input | 1 | One-cycle strobe marking a divided-oscillator edge |
| err_ref_n | output | 1 | Active-low error pulse, low while the reference side is ahead |
| err_vco_n | output | 1 | Active-low error pulse, low while the oscillator side is ahead |
| se_drive | output | 1 | Single-ended error value, meaningful while `se_oe` is 1 |
| se_oe | output | 1 | Output enable for the single-ended error; 0 means high impedance |
| locked | output | 1 | Lock indicator |

## Verification
The bench first applies strobes on the same edge. This separates the shared `MIN_W` window from any one-sided error, and it shows that the lock flag rises. It then applies gaps with the reference side leading and gaps with the oscillator side leading, including a gap of one clock. These show that the pulse width follows the gap and that the single-ended polarity follows the side that leads. A burst of reference strobes with no oscillator edge stands in for a frequency error. A strobe placed exactly on the edge that ends a window checks that the flag is kept, and a reset applied during a pulse checks that it cuts the pulse short.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Number of compared inputs: index 0 is the reference side, 1 the oscillator side.
  localparam int unsigned NSIDE   = 2;
  localparam int unsigned SIDE_RF = 0;
  localparam int unsigned SIDE_VC = 1;

  // What the single-ended output is doing in a given cycle.
  typedef enum logic [1:0] {
    SE_FLOAT = 2'b00,
    SE_PUMP_UP = 2'b01,
    SE_PUMP_DN = 2'b10
  } se_mode_t;

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/pfd_edge_core.sv
module pfd_edge_core
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSIDE-1:0] strobe_i,
  output logic [NSIDE-1:0] seen_o,
  output logic             clr_o
);

  localparam int unsigned CW = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

  logic [NSIDE-1:0] seen_q;
  logic [NSIDE-1:0] seen_d;
  logic [CW-1:0]    win_q;
  logic [CW-1:0]    win_d;
  logic             win_en;
  logic             both;
  logic             clr;

  // Shared window: both sides seen, count MIN_W cycles, then clear.
  always_comb begin
    both   = &seen_q;
    clr    = both && (win_q == LAST);
    win_en = both || (win_q != '0);
    if (!both || clr) begin
      win_d = '0;
    end else begin
      win_d = win_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

  // One remembered-edge flag per side; a strobe on the clearing edge wins.
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic flag_en;

    always_comb begin
      flag_en   = strobe_i[s] || clr;
      seen_d[s] = strobe_i[s] || (seen_q[s] && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_q[s] <= 1'b0;
      end else if (flag_en) begin
        seen_q[s] <= seen_d[s];
      end
    end
  end

  assign seen_o = seen_q;
  assign clr_o  = clr;

endmodule

// File: rtl/pfd_out_enc.sv
module pfd_out_enc
  import pfd_pkg::*;
(
  input  logic [NSIDE-1:0] seen_i,
  output logic             ref_n_o,
  output logic             vco_n_o,
  output logic             se_drive_o,
  output logic             se_oe_o,
  output logic             lone_o
);

  se_mode_t mode;

  always_comb begin
    unique case (seen_i)
      2'b01:   mode = SE_PUMP_UP;
      2'b10:   mode = SE_PUMP_DN;
      default: mode = SE_FLOAT;
    endcase
  end

  always_comb begin
    ref_n_o    = !seen_i[SIDE_RF];
    vco_n_o    = !seen_i[SIDE_VC];
    se_oe_o    = (mode != SE_FLOAT);
    se_drive_o = (mode == SE_PUMP_UP);
    lone_o     = (mode != SE_FLOAT);
  end

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic lone_i,
  input  logic clr_i,
  output logic lock_o
);

  logic lock_q;
  logic lock_d;
  logic err_q;
  logic err_d;
  logic upd_en;

  // err_q remembers a one-sided cycle inside the current comparison.
  always_comb begin
    upd_en = lone_i || clr_i;
    if (lone_i) begin
      err_d  = 1'b1;
      lock_d = 1'b0;
    end else if (clr_i) begin
      err_d  = 1'b0;
      lock_d = lock_q || !err_q;
    end else begin
      err_d  = err_q;
      lock_d = lock_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (upd_en) begin
      err_q  <= err_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/pfd_dual_det.sv
module pfd_dual_det
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge_i,
  input  logic vco_edge_i,
  output logic err_ref_n,
  output logic err_vco_n,
  output logic se_drive,
  output logic se_oe,
  output logic locked
);

  logic             rst_int_n;
  logic [NSIDE-1:0] strobes;
  logic [NSIDE-1:0] seen;
  logic             clr;
  logic             lone;

  assign strobes[SIDE_RF] = ref_edge_i;
  assign strobes[SIDE_VC] = vco_edge_i;

  pfd_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pfd_edge_core #(.MIN_W(MIN_W)) i_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (strobes),
    .seen_o   (seen),
    .clr_o    (clr)
  );

  pfd_out_enc i_enc (
    .seen_i     (seen),
    .ref_n_o    (err_ref_n),
    .vco_n_o    (err_vco_n),
    .se_drive_o (se_drive),
    .se_oe_o    (se_oe),
    .lone_o     (lone)
  );

  pfd_lock_mon i_lock (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lone_i (lone),
    .clr_i  (clr),
    .lock_o (locked)
  );

endmodule

// File: rtl/pfd_dual_det_chk.sv
module pfd_dual_det_chk #(
  parameter int unsigned MIN_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic err_ref_n,
  input logic err_vco_n,
  input logic se_drive,
  input logic se_oe,
  input logic locked
);

  localparam int unsigned RW = $clog2(MIN_W + 2);

  logic [RW-1:0] run_q;
  logic          both_low;

  assign both_low = !err_ref_n && !err_vco_n;

  // Length of the current run of cycles with both outputs low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (both_low) begin
      if (run_q != RW'(MIN_W + 1)) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R1: oscillator side alone drives the single-ended output low
  a_r1_vco_lead_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ref_n && !err_vco_n) |-> (se_oe && !se_drive));

  // R2: reference side alone drives the single-ended output high
  a_r2_ref_lead_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_ref_n && err_vco_n) |-> (se_oe && se_drive));

  // R3: the shared low window never outlasts MIN_W cycles
  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RW'(MIN_W)) |-> !both_low);

  // R5: no drive when both outputs agree
  a_r5_float_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ref_n == err_vco_n) |-> !se_oe);

  // R6: a one-sided cycle drops the lock flag at the next edge
  a_r6_lone_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ref_n != err_vco_n) |=> !locked);

  // R7: lock rises only right after a shared window
  a_r7_rise_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(both_low));

endmodule

bind pfd_dual_det pfd_dual_det_chk #(.MIN_W(MIN_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_ref_n (err_ref_n),
  .err_vco_n (err_vco_n),
  .se_drive  (se_drive),
  .se_oe     (se_oe),
  .locked    (locked)
);

// File: tb/test_pfd_dual_det.sv
module test_pfd_dual_det;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_W      = 2;

  typedef struct {
    logic  rn;
    logic  vn;
    logic  oe;
    logic  drv;
    logic  lk;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_edge_i;
  logic vco_edge_i;
  logic err_ref_n;
  logic err_vco_n;
  logic se_drive;
  logic se_oe;
  logic locked;

  int   total = 0;
  int   bad   = 0;
  logic exp_lock;
  exp_t sb_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pfd_dual_det i_pfd_dual_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_edge_i (ref_edge_i),
    .vco_edge_i (vco_edge_i),
    .err_ref_n  (err_ref_n),
    .err_vco_n  (err_vco_n),
    .se_drive   (se_drive),
    .se_oe      (se_oe),
    .locked     (locked)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(logic rn, logic vn, logic oe, logic drv, logic lk, string req);
    exp_t e;
    e.rn = rn; e.vn = vn; e.oe = oe; e.drv = drv; e.lk = lk; e.req = req;
    sb_q.push_back(e);
  endtask

  // Monitor: compare the slot that ended at the previous rising edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.req, "err_ref_n", err_ref_n, e.rn);
      chk(e.req, "err_vco_n", err_vco_n, e.vn);
      chk(e.req, "se_oe", se_oe, e.oe);
      if (e.oe) chk(e.req, "se_drive", se_drive, e.drv);
      chk(e.req, "locked", locked, e.lk);
    end
  end

  // Driver: reference strobe at slot tr, oscillator strobe at slot tv.
  // Expected values follow R1-style rules: a side is low from its strobe slot
  // until MIN_W slots after the later strobe; lock per R6 and R7.
  task automatic run_pair(int tr, int tv, bit extra_ref, string req);
    int  m;
    int  len;
    logic prev_lone;
    m         = (tr > tv) ? tr : tv;
    len       = m + MIN_W + 2;
    prev_lone = 1'b0;
    for (int k = 0; k < len; k++) begin
      logic rl, vl, lone;
      @(negedge clk);
      ref_edge_i = (k == tr) || (extra_ref && (k == 2 || k == 4) && (k < tv));
      vco_edge_i = (k == tv);
      @(posedge clk);
      #1;
      rl   = (k >= tr) && (k < m + MIN_W);
      vl   = (k >= tv) && (k < m + MIN_W);
      lone = rl ^ vl;
      if (prev_lone) exp_lock = 1'b0;
      else if (k == m + MIN_W && tr == tv) exp_lock = 1'b1;
      push(!rl, !vl, lone, rl && !vl, exp_lock, req);
      prev_lone = lone;
    end
    @(negedge clk);
    ref_edge_i = 1'b0;
    vco_edge_i = 1'b0;
  endtask

  // R10: a reference strobe on the edge that ends a shared window.
  task automatic run_clear_edge();
    logic l0;
    l0 = exp_lock;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      ref_edge_i = (k == 0) || (k == 2);
      vco_edge_i = (k == 0) || (k == 3);
      @(posedge clk);
      #1;
      case (k)
        0, 1:    push(1'b0, 1'b0, 1'b0, 1'b0, l0,   "R10");
        2:       push(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
        3, 4:    push(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        default: push(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
      endcase
    end
    exp_lock = 1'b0;
    @(negedge clk);
    ref_edge_i = 1'b0;
    vco_edge_i = 1'b0;
  endtask

  initial begin
    rst_n      = 1'b0;
    ref_edge_i = 1'b0;
    vco_edge_i = 1'b0;
    exp_lock   = 1'b0;
    repeat (3) @(negedge clk);
    // R8: state during reset
    chk("R8", "err_ref_n", err_ref_n, 1'b1);
    chk("R8", "err_vco_n", err_vco_n, 1'b1);
    chk("R8", "se_oe", se_oe, 1'b0);
    chk("R8", "locked", locked, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", "locked after release", locked, 1'b0);

    run_pair(0, 0, 1'b0, "R3/R5/R7");
    run_pair(0, 0, 1'b0, "R4/R7");
    run_pair(0, 3, 1'b0, "R2/R4/R6");
    run_pair(0, 0, 1'b0, "R7");
    run_pair(4, 1, 1'b0, "R1/R4/R6");
    run_pair(0, 0, 1'b0, "R7");
    run_pair(0, 1, 1'b0, "R2/R4");
    run_pair(0, 0, 1'b0, "R7");
    run_pair(1, 0, 1'b0, "R1/R6");
    run_pair(0, 6, 1'b1, "R9");
    run_pair(0, 0, 1'b0, "R7");
    run_clear_edge();
    repeat (3) @(negedge clk);

    // R8: reset in the middle of a reference pulse
    ref_edge_i = 1'b1;
    @(negedge clk);
    ref_edge_i = 1'b0;
    chk("R8", "pulse before reset", err_ref_n, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R8", "err_ref_n cut", err_ref_n, 1'b1);
    chk("R8", "se_oe cut", se_oe, 1'b0);
    chk("R8", "locked cut", locked, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_lock = 1'b0;
    run_pair(0, 0, 1'b0, "R7");
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule